// File: doc/BRIEF.md
# Page Request Fault and Response Generator

This block sits beside the page-request path of an I/O address translation unit. Each incoming device page request is presented with its device identifier, its last-in-group flag, the unit's directory mode, and the result of the device-context lookup. The lookup result includes the context's page-request enable and its bit that asks for the PASID to be returned in responses. The block sorts the request into one of three outcomes. A clean request with room in the page-request queue is pushed through with a one-cycle `q_push` strobe. A request that hits a fault produces a fault record carrying a cause code. A request that cannot be accepted, whether because of a fault or because the queue is full, produces a group-response message with a status, provided it closes its group.

Three streams use valid/ready. The request stream is `req_*`, the fault record is `flt_*` and the response message is `rsp_*`. Only one request is in flight at a time. `req_ready` is low whenever either output slot holds an item, so back-pressure on either output stops the intake. An output item appears on the cycle after its request is accepted. It stays with stable contents until its own ready is sampled high. Requests that are pushed to the queue produce no output, so these can be accepted on every cycle.

Top module: `prq_resp_gen`

## Requirements
- R1: After reset, `req_ready` is 1, `flt_valid`, `rsp_valid` and `q_push` are 0.
- R2: Mode encoding is Off=0, Bare=1, one/two/three directory levels=2/3/4, and codes 5-7 act as Off. An accepted request in Off gives cause 256 and Response Failure, with the PASID-return bit 0.
- R3: A device identifier with a 1 above bit 5 in mode 2, or above bit 14 in mode 3, gives cause 260 and Invalid Request, with the PASID-return bit 0. Mode 4 accepts the full 24-bit identifier.
- R4: Bare mode gives cause 260 and Invalid Request, with the PASID-return bit 0.
- R5: Lookup encoding is ok=0, load fault=1, not valid=2, misconfigured=3. These give causes 257, 258 and 259 respectively, each with Response Failure and a PASID-return bit of 0.
- R6: When the context is found but its page-request enable is 0, the result is cause 260 and Invalid Request, and the PASID-return bit equals the context's bit.
- R7: When there is no fault and the queue is full, the block returns a Success response carrying the context's PASID-return bit, and produces no fault record.
- R8: When there is no fault and the queue has room, `q_push` is high in the accepting cycle and neither output is produced.
- R9: Checks apply in the order Off, then width or Bare, then load fault, then not valid, then misconfigured, then page-request enable, then queue full. The first match decides the outcome.
- R10: Every faulting request produces a fault record. A response is produced only when the faulting or dropped request has its last-in-group flag set.
- R11: A valid output keeps its contents unchanged until its ready is sampled high. `req_ready` is 0 while either output is valid.
- R12: Status encoding is Success=0, Invalid Request=1, Response Failure=15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Page request present |
| req_ready | output | 1 | Block can take a request |
| req_devid | input | DEVID_W | Requesting device identifier |
| req_last | input | 1 | Request closes its page group |
| xl_mode | input | 3 | Directory mode of the translation unit |
| ctx_lookup | input | 2 | Device-context lookup result |
| ctx_pgreq_en | input | 1 | Context allows page requests |
| ctx_pasid_rsp | input | 1 | Context asks for PASID in responses |
| pq_full | input | 1 | Page-request queue has no room |
| q_push | output | 1 | Push the accepted request into the queue |
| flt_valid | output | 1 | Fault record present |
| flt_ready | input | 1 | Fault record taken |
| flt_cause | output | 12 | Fault cause code |
| flt_devid | output | DEVID_W | Device of the faulting request |
| rsp_valid | output | 1 | Group response present |
| rsp_ready | input | 1 | Group response taken |
| rsp_status | output | 4 | Response status code |
| rsp_devid | output | DEVID_W | Device the response goes to |
| rsp_pasid_en | output | 1 | Response carries the PASID |

## Verification
The bench concentrates on requests that meet several conditions at once: Off together with a bad lookup, Bare together with a load fault, a load fault with the enable cleared, and the enable cleared with a full queue. A chain that tests its conditions in the wrong order reports the wrong cause or status for these. It probes the width limit at exactly 0x3F/0x40 and 0x7FFF/0x8000. An off-by-one in the limit misclassifies one side of each pair. It checks the PASID-return bit under context-less and context-found faults; a design that always forwards the context bit leaks it into Response Failure. Long stalls on one output while the other drains expose a design that restarts intake too early or alters a held record.

// File: rtl/prsg_pkg.sv
package prsg_pkg;

  localparam int CAUSE_W  = 12;
  localparam int STATUS_W = 4;

  typedef enum logic [2:0] {
    MODE_OFF  = 3'd0,
    MODE_BARE = 3'd1,
    MODE_LVL1 = 3'd2,
    MODE_LVL2 = 3'd3,
    MODE_LVL3 = 3'd4
  } xl_mode_e;

  typedef enum logic [1:0] {
    LK_OK     = 2'd0,
    LK_LOADF  = 2'd1,
    LK_INVAL  = 2'd2,
    LK_MISCFG = 2'd3
  } lookup_e;

  localparam logic [STATUS_W-1:0] ST_SUCCESS = 4'd0;
  localparam logic [STATUS_W-1:0] ST_INVREQ  = 4'd1;
  localparam logic [STATUS_W-1:0] ST_RSPFAIL = 4'd15;

  localparam logic [CAUSE_W-1:0] CS_OFF    = 12'd256;
  localparam logic [CAUSE_W-1:0] CS_LOADF  = 12'd257;
  localparam logic [CAUSE_W-1:0] CS_INVAL  = 12'd258;
  localparam logic [CAUSE_W-1:0] CS_MISCFG = 12'd259;
  localparam logic [CAUSE_W-1:0] CS_INVREQ = 12'd260;

  typedef struct packed {
    logic                fault;
    logic [CAUSE_W-1:0]  cause;
    logic                respond;
    logic [STATUS_W-1:0] status;
    logic                pasid_en;
    logic                push;
  } verdict_t;

endpackage

// File: rtl/prsg_classify.sv
module prsg_classify
  import prsg_pkg::*;
#(
  parameter int DEVID_W = 24,
  parameter int LVL1_W  = 6,
  parameter int LVL2_W  = 15
) (
  input  logic [DEVID_W-1:0] devid,
  input  logic               last,
  input  logic [2:0]         mode,
  input  logic [1:0]         lookup,
  input  logic               pgreq_en,
  input  logic               pasid_rsp,
  input  logic               full,
  output verdict_t           verdict
);

  localparam int NLVL = 3;

  logic [NLVL-1:0] wide_v;
  logic            is_off;
  logic            is_bare;
  logic            too_wide;
  logic            drop;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    localparam int LW = (l == 0) ? LVL1_W : (l == 1) ? LVL2_W : DEVID_W;
    if (LW >= DEVID_W) begin : g_full
      assign wide_v[l] = 1'b0;
    end else begin : g_part
      assign wide_v[l] = |devid[DEVID_W-1:LW];
    end
  end

  always_comb begin
    is_off   = 1'b0;
    is_bare  = 1'b0;
    too_wide = 1'b0;
    unique case (mode)
      MODE_BARE: is_bare  = 1'b1;
      MODE_LVL1: too_wide = wide_v[0];
      MODE_LVL2: too_wide = wide_v[1];
      MODE_LVL3: too_wide = wide_v[2];
      default:   is_off   = 1'b1;
    endcase
  end

  always_comb begin
    verdict = '0;
    drop    = 1'b0;
    if (is_off) begin
      verdict.fault  = 1'b1;
      verdict.cause  = CS_OFF;
      verdict.status = ST_RSPFAIL;
    end else if (is_bare || too_wide) begin
      verdict.fault  = 1'b1;
      verdict.cause  = CS_INVREQ;
      verdict.status = ST_INVREQ;
    end else if (lookup == LK_LOADF) begin
      verdict.fault  = 1'b1;
      verdict.cause  = CS_LOADF;
      verdict.status = ST_RSPFAIL;
    end else if (lookup == LK_INVAL) begin
      verdict.fault  = 1'b1;
      verdict.cause  = CS_INVAL;
      verdict.status = ST_RSPFAIL;
    end else if (lookup == LK_MISCFG) begin
      verdict.fault  = 1'b1;
      verdict.cause  = CS_MISCFG;
      verdict.status = ST_RSPFAIL;
    end else if (!pgreq_en) begin
      verdict.fault    = 1'b1;
      verdict.cause    = CS_INVREQ;
      verdict.status   = ST_INVREQ;
      verdict.pasid_en = pasid_rsp;
    end else if (full) begin
      drop             = 1'b1;
      verdict.status   = ST_SUCCESS;
      verdict.pasid_en = pasid_rsp;
    end else begin
      verdict.push = 1'b1;
    end
    verdict.respond = (verdict.fault | drop) & last;
  end

endmodule

// File: rtl/prsg_slot.sv
module prsg_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else begin
      if (load) begin
        valid <= 1'b1;
        dout  <= din;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/prq_resp_gen.sv
module prq_resp_gen
  import prsg_pkg::*;
#(
  parameter int DEVID_W = 24,
  parameter int LVL1_W  = 6,
  parameter int LVL2_W  = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [DEVID_W-1:0]  req_devid,
  input  logic                req_last,
  input  logic [2:0]          xl_mode,
  input  logic [1:0]          ctx_lookup,
  input  logic                ctx_pgreq_en,
  input  logic                ctx_pasid_rsp,
  input  logic                pq_full,
  output logic                q_push,
  output logic                flt_valid,
  input  logic                flt_ready,
  output logic [CAUSE_W-1:0]  flt_cause,
  output logic [DEVID_W-1:0]  flt_devid,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [STATUS_W-1:0] rsp_status,
  output logic [DEVID_W-1:0]  rsp_devid,
  output logic                rsp_pasid_en
);

  localparam int FLT_W = CAUSE_W + DEVID_W;
  localparam int RSP_W = STATUS_W + DEVID_W + 1;

  verdict_t   verdict;
  logic       accept;
  logic [FLT_W-1:0] flt_din, flt_q;
  logic [RSP_W-1:0] rsp_din, rsp_q;

  prsg_classify #(
    .DEVID_W (DEVID_W),
    .LVL1_W  (LVL1_W),
    .LVL2_W  (LVL2_W)
  ) u_classify (
    .devid     (req_devid),
    .last      (req_last),
    .mode      (xl_mode),
    .lookup    (ctx_lookup),
    .pgreq_en  (ctx_pgreq_en),
    .pasid_rsp (ctx_pasid_rsp),
    .full      (pq_full),
    .verdict   (verdict)
  );

  assign req_ready = ~flt_valid & ~rsp_valid;
  assign accept    = req_valid & req_ready;
  assign q_push    = accept & verdict.push;

  assign flt_din = {verdict.cause, req_devid};
  assign rsp_din = {verdict.status, req_devid, verdict.pasid_en};

  prsg_slot #(.W(FLT_W)) u_flt_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept & verdict.fault),
    .din   (flt_din),
    .valid (flt_valid),
    .ready (flt_ready),
    .dout  (flt_q)
  );

  prsg_slot #(.W(RSP_W)) u_rsp_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept & verdict.respond),
    .din   (rsp_din),
    .valid (rsp_valid),
    .ready (rsp_ready),
    .dout  (rsp_q)
  );

  assign {flt_cause, flt_devid}                = flt_q;
  assign {rsp_status, rsp_devid, rsp_pasid_en} = rsp_q;

endmodule

// File: rtl/prsg_checker.sv
module prsg_checker #(
  parameter int DEVID_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_last,
  input logic [2:0]         xl_mode,
  input logic [1:0]         ctx_lookup,
  input logic               ctx_pgreq_en,
  input logic               pq_full,
  input logic               q_push,
  input logic               flt_valid,
  input logic               flt_ready,
  input logic [11:0]        flt_cause,
  input logic [DEVID_W-1:0] flt_devid,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [3:0]         rsp_status,
  input logic [DEVID_W-1:0] rsp_devid,
  input logic               rsp_pasid_en
);

  p_stall_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid || rsp_valid) |-> !req_ready);

  p_flt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_ready) |=> (flt_valid && $stable(flt_cause) && $stable(flt_devid)));

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_status) && $stable(rsp_devid) && $stable(rsp_pasid_en)));

  p_off_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (xl_mode == 3'd0 || xl_mode > 3'd4)) |=>
      (flt_valid && flt_cause == 12'd256));

  p_bare_invreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && xl_mode == 3'd1) |=> (flt_valid && flt_cause == 12'd260));

  p_rspfail_nopasid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 4'd15) |-> !rsp_pasid_en);

  p_success_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 4'd0) |-> !flt_valid);

  p_push_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> (req_valid && req_ready && !pq_full && ctx_lookup == 2'd0 && ctx_pgreq_en));

  p_rsp_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_last));

  p_status_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status == 4'd0 || rsp_status == 4'd1 || rsp_status == 4'd15));

endmodule

bind prq_resp_gen prsg_checker #(.DEVID_W(DEVID_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_last     (req_last),
  .xl_mode      (xl_mode),
  .ctx_lookup   (ctx_lookup),
  .ctx_pgreq_en (ctx_pgreq_en),
  .pq_full      (pq_full),
  .q_push       (q_push),
  .flt_valid    (flt_valid),
  .flt_ready    (flt_ready),
  .flt_cause    (flt_cause),
  .flt_devid    (flt_devid),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_status   (rsp_status),
  .rsp_devid    (rsp_devid),
  .rsp_pasid_en (rsp_pasid_en)
);

// File: tb/prq_resp_gen_bench.sv
module prq_resp_gen_bench;

  localparam int DW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 0, req_last = 0, ctx_pgreq_en = 0, ctx_pasid_rsp = 0, pq_full = 0;
  logic [DW-1:0] req_devid = '0;
  logic [2:0]    xl_mode = '0;
  logic [1:0]    ctx_lookup = '0;
  logic          flt_ready = 1, rsp_ready = 1;
  logic          req_ready, q_push, flt_valid, rsp_valid, rsp_pasid_en;
  logic [11:0]   flt_cause;
  logic [3:0]    rsp_status;
  logic [DW-1:0] flt_devid, rsp_devid;

  prq_resp_gen #(.DEVID_W(DW)) u_prq_resp_gen (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_devid(req_devid), .req_last(req_last),
    .xl_mode(xl_mode), .ctx_lookup(ctx_lookup), .ctx_pgreq_en(ctx_pgreq_en),
    .ctx_pasid_rsp(ctx_pasid_rsp), .pq_full(pq_full), .q_push(q_push),
    .flt_valid(flt_valid), .flt_ready(flt_ready), .flt_cause(flt_cause), .flt_devid(flt_devid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_devid(rsp_devid), .rsp_pasid_en(rsp_pasid_en)
  );

  int    checks = 0;
  int    errors = 0;
  string cur = "R1";

  // reference state
  bit m_fv = 0, m_rv = 0, m_rp = 0;
  int m_fc = 0, m_fd = 0, m_rs = 0, m_rd = 0;

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", cur, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic void judge(output bit f, output int cause, output bit rsp,
                                output int st, output bit pas, output bit push);
    int  md;
    bit  wide, drop;
    md   = int'(xl_mode);
    wide = (md == 2 && req_devid >= 64) || (md == 3 && req_devid >= 32768);
    drop = 0; f = 0; cause = 0; st = 0; pas = 0; push = 0;
    if (md == 0 || md > 4) begin f = 1; cause = 256; st = 15; end
    else if (md == 1 || wide) begin f = 1; cause = 260; st = 1; end
    else if (ctx_lookup == 2'd1) begin f = 1; cause = 257; st = 15; end
    else if (ctx_lookup == 2'd2) begin f = 1; cause = 258; st = 15; end
    else if (ctx_lookup == 2'd3) begin f = 1; cause = 259; st = 15; end
    else if (!ctx_pgreq_en) begin f = 1; cause = 260; st = 1; pas = ctx_pasid_rsp; end
    else if (pq_full) begin drop = 1; st = 0; pas = ctx_pasid_rsp; end
    else push = 1;
    rsp = (f || drop) && req_last;
  endfunction

  // compare this cycle, advance the reference across the next edge
  task automatic cyc();
    bit f, rsp, pas, push, rdy, acc;
    int cause, st;
    #1;
    rdy = !m_fv && !m_rv;
    judge(f, cause, rsp, st, pas, push);
    chk("req_ready", req_ready, rdy);
    chk("q_push", q_push, req_valid && rdy && push);
    chk("flt_valid", flt_valid, m_fv);
    chk("rsp_valid", rsp_valid, m_rv);
    if (m_fv) begin
      chk("flt_cause", flt_cause, m_fc);
      chk("flt_devid", flt_devid, m_fd);
    end
    if (m_rv) begin
      chk("rsp_status", rsp_status, m_rs);
      chk("rsp_devid", rsp_devid, m_rd);
      chk("rsp_pasid_en", rsp_pasid_en, m_rp);
    end
    acc = req_valid && rdy;
    if (m_fv && flt_ready) m_fv = 0;
    if (m_rv && rsp_ready) m_rv = 0;
    if (acc && f) begin m_fv = 1; m_fc = cause; m_fd = int'(req_devid); end
    if (acc && rsp) begin m_rv = 1; m_rs = st; m_rd = int'(req_devid); m_rp = pas; end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(int md, int dev, bit last, int lk, bit en, bit pas, bit full);
    bit took;
    xl_mode = 3'(md); req_devid = DW'(dev); req_last = last; ctx_lookup = 2'(lk);
    ctx_pgreq_en = en; ctx_pasid_rsp = pas; pq_full = full; req_valid = 1;
    do begin
      took = !m_fv && !m_rv;
      cyc();
    end while (!took);
    req_valid = 0;
    repeat (2) cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur = "R1"; cyc();
    // R8 clean requests, back to back
    cur = "R8";
    xl_mode = 3'd4; req_devid = 24'h123456; ctx_lookup = 0; ctx_pgreq_en = 1; req_last = 1;
    req_valid = 1; repeat (3) cyc(); req_valid = 0; cyc();
    cur = "R2";  send(0, 5, 1, 0, 1, 1, 0); send(6, 7, 1, 0, 1, 1, 0);
    cur = "R4";  send(1, 9, 1, 0, 1, 1, 0);
    cur = "R3";  send(2, 'h40, 1, 0, 1, 1, 0); send(2, 'h3F, 1, 0, 1, 0, 0);
    send(3, 'h8000, 1, 0, 1, 1, 0); send(3, 'h7FFF, 1, 0, 1, 0, 0); send(4, 'hFFFFFF, 1, 0, 1, 0, 0);
    cur = "R5";  send(4, 11, 1, 1, 1, 1, 0); send(4, 12, 1, 2, 1, 1, 0); send(4, 13, 1, 3, 1, 1, 0);
    cur = "R6";  send(2, 14, 1, 0, 0, 1, 0); send(2, 15, 1, 0, 0, 0, 0);
    cur = "R7";  send(3, 16, 1, 0, 1, 1, 1); send(3, 17, 0, 0, 1, 1, 1);
    cur = "R9";  send(0, 18, 1, 1, 0, 1, 1); send(1, 19, 1, 1, 1, 1, 0);
    send(4, 20, 1, 1, 0, 1, 1); send(4, 21, 1, 0, 0, 1, 1);
    cur = "R10"; send(4, 22, 0, 2, 1, 1, 0); send(1, 23, 0, 0, 1, 0, 0);
    cur = "R12"; send(4, 24, 1, 0, 0, 0, 0); send(4, 25, 1, 0, 1, 0, 1); send(4, 26, 1, 3, 1, 0, 0);
    // R11 both outputs stalled, then drained one at a time
    cur = "R11";
    flt_ready = 0; rsp_ready = 0;
    send(0, 30, 1, 0, 1, 0, 0);
    xl_mode = 3'd4; req_devid = 24'd31; ctx_lookup = 0; ctx_pgreq_en = 1; pq_full = 0; req_valid = 1;
    repeat (3) cyc();
    flt_ready = 1; repeat (2) cyc();
    rsp_ready = 1; repeat (3) cyc();
    req_valid = 0; cyc();
    // R11 random traffic and back-pressure
    for (int i = 0; i < 400; i++) begin
      req_valid = 1'($urandom_range(0, 1));
      xl_mode = 3'($urandom_range(0, 7));
      req_devid = DW'($urandom_range(0, 70000));
      req_last = 1'($urandom_range(0, 1));
      ctx_lookup = 2'($urandom_range(0, 3));
      ctx_pgreq_en = 1'($urandom_range(0, 3) != 0);
      ctx_pasid_rsp = 1'($urandom_range(0, 1));
      pq_full = 1'($urandom_range(0, 1));
      flt_ready = 1'($urandom_range(0, 2) != 0);
      rsp_ready = 1'($urandom_range(0, 2) != 0);
      cyc();
    end
    req_valid = 0; flt_ready = 1; rsp_ready = 1;
    repeat (3) cyc();
    finish_run();
  end

endmodule